// File: doc/BRIEF.md
# Dual-Output Compare-Match Waveform Timer

This block is one timer channel that produces two pulse-width-modulated waveforms. An up-counter advances on a selectable time base. The base is either the main clock divided by a power of four or an external slow reference pulse. When the counter equals the shared period value, it returns to zero. Each of the two outputs has its own compare value, and for each output a two-bit action is applied on three events: its own compare match, the period match and a software trigger.

The block is programmed through a plain write port. Five addresses hold the mode word, the two compare values, the period and a command word. The command word carries three strobes: start the time base, stop it, and software trigger. A software trigger zeroes the counter and forces each output to its programmed level in the same cycle, whether or not the counter is running. Software uses this to park an output at a fixed level, for example for a duty of zero or of a full period, by leaving the compare actions at "hold".

Top module: `cmpWaveTimer`

## Requirements
- R1: While running, the counter adds one on each time-base tick. On a tick where the counter equals the period register, it becomes zero instead, so one cycle spans period+1 ticks.
- R2: Action codes are 2 bits: 0 hold, 1 drive high, 2 drive low, 3 invert. Output A applies its own-compare action on a tick where the counter equals compare register A, and output B does the same with compare register B.
- R3: The two outputs share the period but have independent compare registers and action sets. One output can run with normal polarity and the other with inverted polarity, each with a different duty.
- R4: A command write with the software-trigger bit (bit 2) zeroes the counter and applies each output's software-trigger action at the same clock edge, even while the time base is stopped.
- R5: When several events hit one output at the same edge, only one action is applied. The software trigger beats the period match, and the period match beats the output's own compare match.
- R6: Command bit 0 starts the time base and bit 1 stops it. Stop wins when both are set. While stopped, the counter and the outputs hold their values.
- R7: The clock-select field (mode bits 2:0) picks the tick source. Values 0, 1, 2 and 3 divide the main clock by 1, 4, 16 and 64. Values 4 to 7 use the slowTick input.
- R8: When the waveform enable (mode bit 3) is clear, no event changes either output, but the counter keeps running.
- R9: After reset, both outputs are low, the counter is zero, the time base is stopped and every register is zero.
- R10: The write port decodes the address as 0 mode, 1 compare A, 2 compare B, 3 period and 4 command. Compare, period and mode writes take effect at the write edge.
- R11: Mode word layout, from bit 4 upward in 2-bit fields: A own-compare, A period-match, A software-trigger, B own-compare, B period-match, B software-trigger actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | WR_W (16 by default) | Write data |
| slowTick | input | 1 | One-cycle pulse from the slow reference, used as a time base |
| outA | output | 1 | Waveform output A |
| outB | output | 1 | Waveform output B |
| count | output | CNT_W (16 by default) | Current counter value |

## Verification
A wrong counter state shows up on the count port at the very next sampled cycle. It also shifts the edges of both outputs by the same amount, so a period error appears at the first wrap, within period+1 ticks. A wrong action or priority decision shows up as a wrong output level right after the edge where the colliding events fall. The bench forces those collisions on purpose: compare equal to period, and a software trigger on the wrap edge. A stuck run flag or a wrong divider shows up as a counter that advances the wrong number of steps across a window whose length is a multiple of the divisor.

// File: rtl/cwtPkg.sv
package cwtPkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } cwtAct_e;

  // mode word, MSB first
  typedef struct packed {
    cwtAct_e    bSw;
    cwtAct_e    bRc;
    cwtAct_e    bOwn;
    cwtAct_e    aSw;
    cwtAct_e    aRc;
    cwtAct_e    aOwn;
    logic       waveEn;
    logic [2:0] clkSel;
  } cwtMode_t;

  typedef struct packed {
    logic clkOn;
    logic clkOff;
    logic swTrig;
  } cwtStrobe_t;

  localparam int MODE_W = $bits(cwtMode_t);

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_CMPA   = 3'd1;
  localparam logic [2:0] ADDR_CMPB   = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_CMD    = 3'd4;

  localparam int CMD_ON  = 0;
  localparam int CMD_OFF = 1;
  localparam int CMD_SW  = 2;

endpackage

// File: rtl/cwtCtrl.sv
module cwtCtrl
  import cwtPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WR_W  = 16,
  parameter int NUM_OUT = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [2:0]                      wrAddr,
  input  logic [WR_W-1:0]                 wrData,
  output cwtMode_t                        modeReg,
  output logic [CNT_W-1:0]                periodVal,
  output logic [NUM_OUT-1:0][CNT_W-1:0]   cmpVal,
  output cwtStrobe_t                      stb
);

  logic cmdWr;
  assign cmdWr = wrEn && (wrAddr == ADDR_CMD);

  // command strobes act in the write cycle itself
  assign stb.clkOn  = cmdWr && wrData[CMD_ON];
  assign stb.clkOff = cmdWr && wrData[CMD_OFF];
  assign stb.swTrig = cmdWr && wrData[CMD_SW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= '0;
      periodVal <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_MODE)   modeReg   <= cwtMode_t'(wrData[MODE_W-1:0]);
      if (wrAddr == ADDR_PERIOD) periodVal <= wrData[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cmp
    localparam logic [2:0] MY_ADDR = ADDR_CMPA + 3'(g);
    always_ff @(posedge clk) begin
      if (!rstN)                            cmpVal[g] <= '0;
      else if (wrEn && wrAddr == MY_ADDR)   cmpVal[g] <= wrData[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/cwtDatapath.sv
module cwtDatapath
  import cwtPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_OUT  = 2,
  parameter int NUM_DIV  = 4,
  parameter int DIV_STEP = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cwtStrobe_t                    stb,
  input  logic [2:0]                    clkSel,
  input  logic                          slowTick,
  input  logic [CNT_W-1:0]              periodVal,
  input  logic [NUM_OUT-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]              count,
  output logic                          running,
  output logic                          tick,
  output logic                          rcHit,
  output logic [NUM_OUT-1:0]            cmpHit
);

  localparam int PRE_RAW = DIV_STEP * (NUM_DIV - 1);
  localparam int PRE_W   = (PRE_RAW < 1) ? 1 : PRE_RAW;

  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] divTick;
  logic               advance;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    if (g == 0) begin : g_full
      assign divTick[g] = 1'b1;
    end else begin : g_part
      assign divTick[g] = &preCnt[DIV_STEP*g-1:0];
    end
  end

  always_comb begin
    tick = slowTick;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (int'(clkSel) == i) tick = divTick[i];
    end
  end

  assign advance = running && tick;
  assign rcHit   = advance && (count == periodVal);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_hit
    assign cmpHit[g] = advance && (count == cmpVal[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           running <= 1'b0;
    else if (stb.clkOff) running <= 1'b0;
    else if (stb.clkOn)  running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           count <= '0;
    else if (stb.swTrig) count <= '0;
    else if (rcHit)      count <= '0;
    else if (advance)    count <= count + 1'b1;
  end

endmodule

// File: rtl/cwtPin.sv
module cwtPin
  import cwtPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    waveEn,
  input  logic    swEvt,
  input  logic    rcEvt,
  input  logic    ownEvt,
  input  cwtAct_e actSw,
  input  cwtAct_e actRc,
  input  cwtAct_e actOwn,
  output logic    level
);

  cwtAct_e pick;

  always_comb begin
    pick = ACT_HOLD;
    if (swEvt)       pick = actSw;
    else if (rcEvt)  pick = actRc;
    else if (ownEvt) pick = actOwn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= 1'b0;
    end else if (waveEn) begin
      case (pick)
        ACT_SET: level <= 1'b1;
        ACT_CLR: level <= 1'b0;
        ACT_TOG: level <= ~level;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cmpWaveTimer.sv
module cmpWaveTimer
  import cwtPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_DIV  = 4,
  parameter int DIV_STEP = 2,
  localparam int WR_W    = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [WR_W-1:0]  wrData,
  input  logic             slowTick,
  output logic             outA,
  output logic             outB,
  output logic [CNT_W-1:0] count
);

  localparam int NUM_OUT = 2;

  cwtMode_t                        modeReg;
  cwtStrobe_t                      stb;
  logic [CNT_W-1:0]                periodVal;
  logic [NUM_OUT-1:0][CNT_W-1:0]   cmpVal;
  logic                            running;
  logic                            tick;
  logic                            rcHit;
  logic [NUM_OUT-1:0]              cmpHit;
  logic [NUM_OUT-1:0]              pinLvl;
  cwtAct_e                         actSw  [NUM_OUT];
  cwtAct_e                         actRc  [NUM_OUT];
  cwtAct_e                         actOwn [NUM_OUT];

  cwtCtrl #(.CNT_W(CNT_W), .WR_W(WR_W), .NUM_OUT(NUM_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeReg(modeReg), .periodVal(periodVal), .cmpVal(cmpVal), .stb(stb)
  );

  cwtDatapath #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT), .NUM_DIV(NUM_DIV),
                .DIV_STEP(DIV_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .clkSel(modeReg.clkSel),
    .slowTick(slowTick), .periodVal(periodVal), .cmpVal(cmpVal),
    .count(count), .running(running), .tick(tick), .rcHit(rcHit),
    .cmpHit(cmpHit)
  );

  assign actSw[0]  = modeReg.aSw;
  assign actRc[0]  = modeReg.aRc;
  assign actOwn[0] = modeReg.aOwn;
  assign actSw[1]  = modeReg.bSw;
  assign actRc[1]  = modeReg.bRc;
  assign actOwn[1] = modeReg.bOwn;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    cwtPin u_pin (
      .clk(clk), .rstN(rstN), .waveEn(modeReg.waveEn),
      .swEvt(stb.swTrig), .rcEvt(rcHit), .ownEvt(cmpHit[g]),
      .actSw(actSw[g]), .actRc(actRc[g]), .actOwn(actOwn[g]),
      .level(pinLvl[g])
    );
  end

  assign outA = pinLvl[0];
  assign outB = pinLvl[1];

endmodule

// File: rtl/cwtChecker.sv
module cwtChecker
  import cwtPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] periodVal,
  input logic             running,
  input logic             tick,
  input logic             swTrig,
  input logic             clkOff,
  input logic             waveEn,
  input logic [1:0]       actASw,
  input logic             outA,
  input logic             outB
);

  // R1: step by one on a tick below the period
  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && !swTrig && count != periodVal)
      |=> count == CNT_W'($past(count) + 1'b1));

  // R1: wrap to zero on period match
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && !swTrig && count == periodVal) |=> count == '0);

  // R4: software trigger zeroes the counter
  a_r4_sw_zero: assert property (@(posedge clk) disable iff (!rstN)
    swTrig |=> count == '0);

  // R5: software trigger action wins over any other event
  a_r5_sw_first: assert property (@(posedge clk) disable iff (!rstN)
    (swTrig && waveEn && actASw == 2'd1) |=> outA);

  // R6: stop wins and a stopped counter holds
  a_r6_off_wins: assert property (@(posedge clk) disable iff (!rstN)
    clkOff |=> !running);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !swTrig) |=> $stable(count));

  // R8: outputs frozen while waveform mode is off
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !waveEn |=> ($stable(outA) && $stable(outB)));

endmodule

bind cmpWaveTimer cwtChecker #(.CNT_W(CNT_W)) u_cwtChecker (
  .clk(clk), .rstN(rstN), .count(count), .periodVal(periodVal),
  .running(running), .tick(tick), .swTrig(stb.swTrig), .clkOff(stb.clkOff),
  .waveEn(modeReg.waveEn), .actASw(modeReg.aSw), .outA(outA), .outB(outB)
);

// File: tb/test_cmpWaveTimer.sv
module test_cmpWaveTimer;

  localparam int CNT_W = 16;
  localparam int HOLD = 0, SET = 1, CLR = 2, TOG = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [2:0]       wrAddr;
  logic [15:0]      wrData;
  logic             slowTick;
  logic             outA, outB;
  logic [CNT_W-1:0] count;

  int nChecks = 0;
  int nFails  = 0;
  bit slowEn  = 1'b0;
  int slowCnt = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cmpWaveTimer #(.CNT_W(CNT_W)) i_cmpWaveTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slowTick(slowTick), .outA(outA), .outB(outB), .count(count)
  );

  // slow reference: one pulse every 5 cycles
  always @(negedge clk) begin
    slowCnt  <= (slowCnt == 4) ? 0 : slowCnt + 1;
    slowTick <= slowEn && (slowCnt == 0);
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(int sel, int wave, int aOwn, int aRc,
                                      int aSw, int bOwn, int bRc, int bSw);
    return {2'(bSw), 2'(bRc), 2'(bOwn), 2'(aSw), 2'(aRc), 2'(aOwn),
            1'(wave), 3'(sel)};
  endfunction

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(int addr, int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    check("R9 count", int'(count), 0);
    check("R9 outA", int'(outA), 0);
    check("R9 outB", int'(outB), 0);
    repeat (5) @(negedge clk);
    check("R9 stopped", int'(count), 0);
  endtask

  task automatic tTwoPolarity();
    // R3 R10 R11: A normal duty 3, B inverted duty 6, period 9
    wr(3, 9); wr(1, 3); wr(2, 6);
    wr(0, mk(0, 1, CLR, SET, CLR, SET, CLR, SET));
    wr(4, 5);
    for (int j = 0; j <= 40; j++) begin
      if (j > 0) @(negedge clk);
      check("R1 count", int'(count), j % 10);
      check("R2 outA", int'(outA), (j >= 10) ? int'((j % 10) <= 3) : 0);
      check("R3 outB", int'(outB), (j >= 10) ? int'((j % 10) >= 7) : 1);
    end
  endtask

  task automatic tRcOverOwn();
    int bRef;
    wr(4, 2);
    wr(1, 9);
    bRef = int'(outB);
    wr(0, mk(0, 1, CLR, SET, CLR, HOLD, HOLD, HOLD));
    wr(4, 5);
    for (int j = 0; j <= 30; j++) begin
      if (j > 0) @(negedge clk);
      check("R5 rc over own", int'(outA), (j >= 10) ? 1 : 0);
      check("R2 hold B", int'(outB), bRef);
    end
  endtask

  task automatic tSwOverRc();
    int guard = 0;
    while (count != 9 && guard < 20) begin @(negedge clk); guard++; end
    check("R5 reached wrap", int'(count), 9);
    wr(4, 4);
    check("R5 sw over rc outA", int'(outA), 0);
    check("R4 count", int'(count), 0);
    @(negedge clk);
    check("R4 restart", int'(count), 1);
    check("R5 outA after", int'(outA), 0);
  endtask

  task automatic tStop();
    int c0, a0;
    wr(4, 2);
    c0 = int'(count); a0 = int'(outA);
    repeat (10) @(negedge clk);
    check("R6 hold count", int'(count), c0);
    check("R6 hold outA", int'(outA), a0);
    wr(0, mk(0, 1, CLR, SET, SET, HOLD, HOLD, HOLD));
    wr(4, 6);
    check("R4 stopped sw outA", int'(outA), 1);
    check("R4 stopped sw count", int'(count), 0);
    repeat (5) @(negedge clk);
    check("R6 still held", int'(count), 0);
    wr(4, 3);
    repeat (5) @(negedge clk);
    check("R6 off wins", int'(count), 0);
  endtask

  task automatic tWaveOff();
    wr(3, 5); wr(1, 2);
    wr(0, mk(0, 1, CLR, CLR, SET, HOLD, HOLD, HOLD));
    wr(4, 5);
    check("R4 sw set", int'(outA), 1);
    wr(0, mk(0, 0, CLR, CLR, CLR, HOLD, HOLD, HOLD));
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      check("R8 outA frozen", int'(outA), 1);
    end
    check("R8 counting", int'(count), (21 % 6));
    wr(4, 4);
    check("R8 sw ignored", int'(outA), 1);
  endtask

  task automatic tToggle();
    wr(3, 4); wr(1, 0);
    wr(0, mk(0, 1, HOLD, TOG, CLR, HOLD, HOLD, HOLD));
    wr(4, 5);
    for (int j = 0; j <= 30; j++) begin
      if (j > 0) @(negedge clk);
      check("R2 toggle", int'(outA), (j / 5) % 2);
    end
  endtask

  task automatic tDivide();
    wr(3, 1000);
    wr(0, mk(1, 1, HOLD, HOLD, HOLD, HOLD, HOLD, HOLD));
    wr(4, 5);
    repeat (40) @(negedge clk);
    check("R7 div4", int'(count), 10);
    wr(0, mk(2, 1, HOLD, HOLD, HOLD, HOLD, HOLD, HOLD));
    wr(4, 5);
    repeat (64) @(negedge clk);
    check("R7 div16", int'(count), 4);
    slowEn = 1'b1;
    wr(0, mk(4, 1, HOLD, HOLD, HOLD, HOLD, HOLD, HOLD));
    repeat (6) @(negedge clk);
    wr(4, 5);
    repeat (50) @(negedge clk);
    check("R7 slow", int'(count), 10);
    slowEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; slowTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTwoPolarity();
    tRcOverOwn();
    tSwOverRc();
    tStop();
    tWaveOff();
    tToggle();
    tDivide();
    finishRun();
  end

endmodule